// File: doc/BRIEF.md
# FM0 Frame Line Transmitter

This block turns a stream of bytes into a self-clocking FM0 (differential Manchester, space) waveform for a half-duplex shared line. Every bit cell starts with a level change on the line. A zero bit adds a second change halfway through its cell, and a one bit does not. Cell timing comes from a 16x oversample enable pulse on the single system clock, so a cell lasts sixteen enable pulses.

A frame begins when the first byte is accepted on an idle transmitter. The block first sends an optional preamble of 0 to 16 bits taken from a pattern input. It then sends the payload least-significant bit first, with no framing changes. After the byte marked last, it appends a fixed `0x7E` trailer without any further input. The request-to-send output enables an external differential driver and stays high for the whole frame. The busy output mirrors request-to-send so that a local receiver can be gated off. A started frame always runs to its end. If the data source falls behind in mid-frame, a one-cycle error pulse is raised and the previous byte is sent again.

Top module: `fm0_frame_tx`

## Requirements
- R1: On the first oversample enable of every bit cell in a frame, `line_out` inverts, whatever the bit value.
- R2: On the ninth enable of a cell, `line_out` inverts again if the bit is 0 and stays put if it is 1. On every other enable in the cell, it stays put.
- R3: `line_out` changes only on clock edges where `os_tick` is high. A cell spans exactly 16 enables.
- R4: `rts_out` and `tx_busy` rise on the edge that accepts the opening byte of a frame. They fall on the edge that ends the last trailer cell, and they stay high continuously in between.
- R5: The preamble sends the low `min(sync_len,16)` bits of `sync_pattern`, bit 0 first. A length of 0 sends no preamble. Both inputs are captured when the frame starts, so later changes do not affect the frame in progress.
- R6: Payload bytes are sent in arrival order, bit 0 first, with no inserted bits.
- R7: After the byte accepted with `in_last` high, the eight bits of `0x7E` are sent, bit 0 first, and then the frame ends.
- R8: `in_ready` is high whenever the block is idle. During a frame, it is high only while the one-byte holding slot is empty and no byte marked last has been taken yet.
- R9: If a non-last byte finishes and no next byte is held, `underrun` pulses high for one clock and that same byte is sent again.
- R10: Between frames, `line_out` keeps its last level and `rts_out` is low, whatever `os_tick` does.
- R11: A frame always lasts exactly (preamble bits + 8 × bytes sent, including repeats + 8) cells. No input can cut it short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | 16x oversample enable, one clock wide |
| sync_pattern | input | 16 | Preamble bits, bit 0 sent first |
| sync_len | input | 5 | Preamble length in bits (0 means none, clamped to 16) |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte value |
| in_last | input | 1 | Offered byte closes the payload |
| in_ready | output | 1 | Block can take the offered byte |
| line_out | output | 1 | FM0 coded line level |
| rts_out | output | 1 | Request-to-send, driver enable |
| tx_busy | output | 1 | Frame in progress, used to gate a receiver |
| underrun | output | 1 | One-clock pulse when the source fell behind |

## Verification
The assertions assume three things about the inputs. `os_tick` is never high on two consecutive clocks. The source holds `in_valid`, `in_data` and `in_last` steady until a handshake completes. `sync_pattern` and `sync_len` are stable on the accepting edge. The bench produces `os_tick` every second clock from a single process on the falling edge. It changes handshake signals only on falling edges and only after the previous byte has been taken. It alters the preamble inputs only after a frame has started, to show that they are captured at the start.

// File: rtl/fm0_tx_pkg.sv
package fm0_tx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SYNC = 2'd1,
    PH_DATA = 2'd2,
    PH_POST = 2'd3
  } tx_phase_e;

  // number of preamble bits actually sent for a requested length
  function automatic int unsigned preamble_bits(int unsigned req, int unsigned cap);
    return (req > cap) ? cap : req;
  endfunction

  // FM0: a zero bit carries an extra change in mid cell
  function automatic logic mid_flip(logic bit_val);
    return ~bit_val;
  endfunction

endpackage

// File: rtl/fm0_bit_timer.sv
module fm0_bit_timer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic os_tick,
  output logic cell_start,
  output logic mid_pt,
  output logic cell_end
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(OVS - 1);
  localparam logic [CW-1:0] MID_IDX  = CW'(OVS / 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!active) begin
      cnt <= '0;
    end else if (os_tick) begin
      cnt <= (cnt == LAST_IDX) ? '0 : cnt + 1'b1;
    end
  end

  assign cell_start = active && os_tick && (cnt == '0);
  assign mid_pt     = active && os_tick && (cnt == MID_IDX);
  assign cell_end   = active && os_tick && (cnt == LAST_IDX);
endmodule

// File: rtl/fm0_line_coder.sv
module fm0_line_coder
  import fm0_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cell_start,
  input  logic mid_pt,
  input  logic cur_bit,
  output logic line_out
);
  logic flip;

  assign flip = cell_start || (mid_pt && mid_flip(cur_bit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_out <= 1'b0;
    else if (flip) line_out <= ~line_out;
  end
endmodule

// File: rtl/fm0_frame_seq.sv
module fm0_frame_seq
  import fm0_tx_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          SW       = 16,
  parameter int          LW       = 5,
  parameter logic [DW-1:0] POST_BYTE = 8'h7E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sync_pattern,
  input  logic [LW-1:0] sync_len,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  input  logic          cell_end,
  output logic          in_ready,
  output logic          active,
  output logic          cur_bit,
  output logic          underrun
);
  localparam int SHW  = (SW > DW) ? SW : DW;
  localparam int CNTW = $clog2(SHW + 1);
  localparam logic [CNTW-1:0] BYTE_BITS = CNTW'(DW);

  tx_phase_e       phase;
  logic [SHW-1:0]  shreg;
  logic [CNTW-1:0] bits_left;
  logic [DW-1:0]   hbuf, cur_byte;
  logic            hbuf_vld, hbuf_last, cur_last, got_last, underrun_q;
  logic            take, start;
  logic [CNTW-1:0] eff_len;

  assign in_ready = !hbuf_vld && !got_last;
  assign take     = in_valid && in_ready;
  assign start    = (phase == PH_IDLE) && take;
  assign eff_len  = CNTW'(preamble_bits(int'(sync_len), SW));
  assign active   = (phase != PH_IDLE);
  assign cur_bit  = shreg[0];
  assign underrun = underrun_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      shreg      <= '0;
      bits_left  <= '0;
      hbuf       <= '0;
      hbuf_vld   <= 1'b0;
      hbuf_last  <= 1'b0;
      cur_byte   <= '0;
      cur_last   <= 1'b0;
      got_last   <= 1'b0;
      underrun_q <= 1'b0;
    end else begin
      underrun_q <= 1'b0;
      if (start) begin
        got_last <= in_last;
        if (eff_len != '0) begin
          phase     <= PH_SYNC;
          shreg     <= SHW'(sync_pattern);
          bits_left <= eff_len;
          hbuf      <= in_data;
          hbuf_vld  <= 1'b1;
          hbuf_last <= in_last;
        end else begin
          phase     <= PH_DATA;
          shreg     <= SHW'(in_data);
          bits_left <= BYTE_BITS;
          cur_byte  <= in_data;
          cur_last  <= in_last;
        end
      end else begin
        if (take) begin
          hbuf      <= in_data;
          hbuf_vld  <= 1'b1;
          hbuf_last <= in_last;
          if (in_last) got_last <= 1'b1;
        end
        if (cell_end) begin
          if (bits_left == CNTW'(1)) begin
            bits_left <= BYTE_BITS;
            unique case (phase)
              PH_SYNC: begin
                phase    <= PH_DATA;
                shreg    <= SHW'(hbuf);
                cur_byte <= hbuf;
                cur_last <= hbuf_last;
                hbuf_vld <= 1'b0;
              end
              PH_DATA: begin
                if (cur_last) begin
                  phase <= PH_POST;
                  shreg <= SHW'(POST_BYTE);
                end else if (hbuf_vld) begin
                  shreg    <= SHW'(hbuf);
                  cur_byte <= hbuf;
                  cur_last <= hbuf_last;
                  hbuf_vld <= 1'b0;
                end else begin
                  shreg      <= SHW'(cur_byte);
                  underrun_q <= 1'b1;
                end
              end
              PH_POST: begin
                phase    <= PH_IDLE;
                got_last <= 1'b0;
              end
              default: phase <= PH_IDLE;
            endcase
          end else begin
            shreg     <= shreg >> 1;
            bits_left <= bits_left - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fm0_frame_tx.sv
module fm0_frame_tx #(
  parameter int DW  = 8,
  parameter int SW  = 16,
  parameter int LW  = $clog2(SW) + 1,
  parameter int OVS = 16,
  parameter logic [DW-1:0] POST_BYTE = 8'h7E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic [SW-1:0] sync_pattern,
  input  logic [LW-1:0] sync_len,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          line_out,
  output logic          rts_out,
  output logic          tx_busy,
  output logic          underrun
);
  logic active, cur_bit;
  logic cell_start, mid_pt, cell_end;

  fm0_frame_seq #(
    .DW(DW), .SW(SW), .LW(LW), .POST_BYTE(POST_BYTE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .sync_pattern(sync_pattern), .sync_len(sync_len),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .cell_end(cell_end),
    .in_ready(in_ready), .active(active), .cur_bit(cur_bit),
    .underrun(underrun)
  );

  fm0_bit_timer #(.OVS(OVS)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(active), .os_tick(os_tick),
    .cell_start(cell_start), .mid_pt(mid_pt), .cell_end(cell_end)
  );

  fm0_line_coder u_coder (
    .clk(clk), .rst_n(rst_n), .cell_start(cell_start), .mid_pt(mid_pt),
    .cur_bit(cur_bit), .line_out(line_out)
  );

  assign rts_out = active;
  assign tx_busy = active;
endmodule

// File: rtl/fm0_tx_chk.sv
module fm0_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic os_tick,
  input logic in_valid,
  input logic in_ready,
  input logic line_out,
  input logic rts_out,
  input logic tx_busy,
  input logic underrun,
  input logic cell_start,
  input logic mid_pt,
  input logic cell_end,
  input logic cur_bit
);
  // R1
  cell_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_start |=> (line_out != $past(line_out)));

  // R2
  one_no_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_pt && cur_bit) |=> $stable(line_out));

  // R3
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !os_tick |=> $stable(line_out));

  // R4
  rts_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts_out) |-> $past(cell_end));

  // R4
  rts_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_out) |-> $past(in_valid && in_ready));

  // R8
  hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && in_valid && in_ready) |=> !in_ready);

  // R9
  underrun_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

  // R9
  underrun_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> tx_busy);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |=> $stable(line_out));
endmodule

bind fm0_frame_tx fm0_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
  .in_valid(in_valid), .in_ready(in_ready),
  .line_out(line_out), .rts_out(rts_out), .tx_busy(tx_busy),
  .underrun(underrun),
  .cell_start(cell_start), .mid_pt(mid_pt), .cell_end(cell_end),
  .cur_bit(cur_bit)
);

// File: tb/sim_fm0_frame_tx.sv
`timescale 1ns/1ps
module sim_fm0_frame_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        os_tick = 1'b0;
  logic [15:0] sync_pattern = '0;
  logic [4:0]  sync_len = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready, line_out, rts_out, tx_busy, underrun;

  int n_tests = 0;
  int n_fail  = 0;
  int cells_seen = 0;
  int underruns = 0;
  bit exp_q[$];

  always #2 clk = ~clk;

  fm0_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
    .sync_pattern(sync_pattern), .sync_len(sync_len),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .line_out(line_out), .rts_out(rts_out),
    .tx_busy(tx_busy), .underrun(underrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---- monitor and tick source (single falling-edge process) ----
  int  k = 0;
  int  tdiv = 0;
  logic prev_line = 1'b0;
  bit  tick_was = 0, busy_pre = 0, tgl = 0, got = 0, want = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      k = 0; tdiv = 0; tick_was = 0; busy_pre = 0;
      prev_line = line_out; os_tick = 1'b0;
    end else begin
      tgl = (line_out != prev_line);
      if (underrun) underruns++;
      check(rts_out == tx_busy, "R4 rts vs busy", rts_out, tx_busy);
      if (!busy_pre) begin
        check(!tgl, "R10 idle line held", tgl, 0);
        check(!rts_out || tx_busy, "R10 rts low idle", rts_out, 0);
      end
      if (tick_was && busy_pre) begin
        if (k == 0) begin
          check(tgl, "R1 boundary flip", tgl, 1);
        end else if (k == 8) begin
          got = !tgl;
          if (exp_q.size() == 0) begin
            check(0, "R11 extra cell", 1, 0);
          end else begin
            want = exp_q.pop_front();
            check(got == want, "R2/R5/R6/R7 bit value", got, want);
          end
        end else begin
          check(!tgl, "R3 no extra flip", tgl, 0);
        end
        if (k == 15) begin k = 0; cells_seen++; end
        else k++;
      end else if (tick_was == 0 && busy_pre) begin
        check(!tgl, "R3 change off tick", tgl, 0);
      end
      if (!tx_busy) k = 0;
      prev_line = line_out;
      busy_pre  = tx_busy;
      tdiv++;
      os_tick   = tdiv[0];
      tick_was  = os_tick;
    end
  end

  // ---- driver side ----
  task automatic push_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
  endtask

  function automatic int clamp_len(input int len);
    return (len > 16) ? 16 : len;
  endfunction

  task automatic push_sync(input logic [15:0] pat, input int len);
    for (int i = 0; i < clamp_len(len); i++) exp_q.push_back(pat[i]);
  endtask

  task automatic put_byte(input logic [7:0] b, input bit last);
    in_valid = 1'b1; in_data = b; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic finish_frame(input int exp_cells, input int c0, input int u0cnt, input int exp_und);
    logic held;
    while (tx_busy) @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11 all bits sent", exp_q.size(), 0);
    check(cells_seen - c0 == exp_cells, "R11 frame length", cells_seen - c0, exp_cells);
    check(underruns - u0cnt == exp_und, "R9 underrun count", underruns - u0cnt, exp_und);
    check(in_ready == 1'b1, "R8 ready when idle", in_ready, 1);
    held = line_out;
    repeat (100) @(negedge clk);
    check(line_out == held, "R10 level held", line_out, held);
    check(rts_out == 1'b0, "R10 rts low", rts_out, 0);
    exp_q.delete();
  endtask

  task automatic run_frame(input logic [15:0] pat, input int len, input logic [7:0] b0,
                           input logic [7:0] b1, input logic [7:0] b2, input int nb);
    int c0, u0cnt;
    logic [7:0] bs [3];
    bs[0] = b0; bs[1] = b1; bs[2] = b2;
    c0 = cells_seen; u0cnt = underruns;
    sync_pattern = pat; sync_len = 5'(len);
    push_sync(pat, len);
    for (int i = 0; i < nb; i++) push_byte(bs[i]);
    push_byte(8'h7E);
    for (int i = 0; i < nb; i++) begin
      put_byte(bs[i], i == nb - 1);
      if (i == 0) begin
        sync_pattern = ~pat; sync_len = 5'd3;   // R5: must not affect frame
        check(rts_out && tx_busy, "R4 rts up at start", rts_out, 1);
        if (clamp_len(len) > 0)
          check(in_ready == 1'b0, "R8 slot full during preamble", in_ready, 0);
      end
    end
    check(in_ready == 1'b0, "R8 ready low after last", in_ready, 0);
    finish_frame(clamp_len(len) + 8 * nb + 8, c0, u0cnt, 0);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int c0, u0cnt;
    repeat (5) @(negedge clk);
    check(line_out == 1'b0, "R10 reset line", line_out, 0);
    check(rts_out == 1'b0, "R4 reset rts", rts_out, 0);
    check(tx_busy == 1'b0, "R4 reset busy", tx_busy, 0);
    check(in_ready == 1'b1, "R8 reset ready", in_ready, 1);
    check(underrun == 1'b0, "R9 reset underrun", underrun, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    run_frame(16'hA5C3, 16, 8'h00, 8'hFF, 8'h35, 3);   // full preamble
    run_frame(16'h0000, 0,  8'h81, 8'h00, 8'h00, 1);   // no preamble
    run_frame(16'h0013, 5,  8'h6C, 8'hE1, 8'h00, 2);   // short preamble
    run_frame(16'h3CF0, 31, 8'h5A, 8'h00, 8'h00, 1);   // clamp to 16

    // R9 underrun: second byte arrives late, first byte repeated
    c0 = cells_seen; u0cnt = underruns;
    sync_pattern = '0; sync_len = '0;
    push_byte(8'h96); push_byte(8'h96); push_byte(8'h4B); push_byte(8'h7E);
    put_byte(8'h96, 1'b0);
    repeat (300) @(negedge clk);
    check(tx_busy == 1'b1, "R11 no abort on underrun", tx_busy, 1);
    put_byte(8'h4B, 1'b1);
    finish_frame(32, c0, u0cnt, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule